// File: doc/BRIEF.md
# Power-Stage Operating Mode and Protection Arbiter

This block decides how a battery-fed boost/bypass power stage may run. Each clock it takes two board-level mode pins, a two-bit override field from a configuration register, and digitized readings of input voltage and die temperature. From these it picks one of three operating modes and grants or withholds permission for the three power switches. The modes are: off, forced pass-through, and automatic boost/bypass.

Four hysteretic comparators turn the readings into protection flags. Low supply, high supply and over-temperature each remove permission from every switch at once. A separate warm-die flag is only reported. Automatic mode needs the enable pin to have been high for a qualification window first, which is just over 60 µs at the default clock. Until that window has run, the arbiter holds pass-through. While the mode is off, a discharge switch on the output is granted.

Voltage codes are 10 mV per LSB and temperature codes are 1 °C per LSB. All thresholds are parameters. Every output is registered, so each one reflects the inputs sampled at the previous rising clock edge.

Top module: `power_mode_arbiter`

## Requirements
- R1: While `en_pin` is low, `mode` becomes 2'b00 (off) regardless of `nbyp_pin` and `ovr_sel`.
- R2: With `en_pin` high, `ovr_sel` = 2'b00 and `nbyp_pin` low, `mode` becomes 2'b01 (pass-through).
- R3: With `en_pin` high, `ovr_sel` = 2'b00 and `nbyp_pin` high, `mode` becomes 2'b10 (auto). This happens only once `en_pin` has been sampled high on QUAL_CYCLES consecutive edges (default 3001). Before that, `mode` stays 2'b01.
- R4: With `en_pin` high, the override field wins over `nbyp_pin`. The value 2'b10 gives pass-through and 2'b11 gives off. The value 2'b01 gives auto, under the same qualification as R3, and pass-through until then.
- R5: `uv_flag` sets when `vin_code` < 160, clears when `vin_code` > 170, and otherwise holds. Its reset value is 1.
- R6: `ov_flag` sets when `vin_code` > 600, clears when `vin_code` < 570, and otherwise holds. Its reset value is 0.
- R7: `ot_flag` sets when `temp_code` > 160, clears when `temp_code` < 140, and otherwise holds. Its reset value is 0.
- R8: `hot_flag` sets when `temp_code` > 100, clears when `temp_code` < 90, and otherwise holds. It has no effect on any switch grant.
- R9: The switch grants depend on the mode. Off grants only `dis_en`. Pass-through grants only `byp_en`. Auto grants `ls_en`, `hs_en` and `byp_en`.
- R10: Whenever `uv_flag`, `ov_flag` or `ot_flag` is 1, `ls_en`, `hs_en` and `byp_en` are 0 in that same cycle.
- R11: All outputs update one clock after the inputs are sampled. The reset state is off, `dis_en` = 1, `uv_flag` = 1, and every other output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Enable pin level |
| nbyp_pin | input | 1 | Low requests pass-through, high requests auto |
| ovr_sel | input | 2 | Register override: 00 pins, 01 auto, 10 pass-through, 11 off |
| vin_code | input | 10 | Input voltage, 10 mV/LSB |
| temp_code | input | 8 | Die temperature, 1 °C/LSB |
| mode | output | 2 | 00 off, 01 pass-through, 10 auto |
| ls_en | output | 1 | Low-side switch permission |
| hs_en | output | 1 | High-side switch permission |
| byp_en | output | 1 | Bypass switch permission |
| dis_en | output | 1 | Output discharge switch on |
| uv_flag | output | 1 | Input undervoltage |
| ov_flag | output | 1 | Input overvoltage |
| ot_flag | output | 1 | Over-temperature |
| hot_flag | output | 1 | Warm-die indication |

## Verification
Every mode, flag and grant is due on the first rising edge after the stimulus is applied. The one exception is the auto entry, which is due exactly on the QUAL_CYCLES-th consecutive edge with the enable high. The bench applies stimulus on falling edges and queues the expected outputs for that one-edge latency. It compares them 2 ns after the next rising edge. The qualification window is checked on the edge just before the auto entry is due and on the edge where it is due. Hysteresis is checked with readings between the two thresholds, approached from both sides.

// File: rtl/pmarb_pkg.sv
package pmarb_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_THRU = 2'b01,
        MODE_AUTO = 2'b10
    } op_mode_e;

    typedef enum logic [1:0] {
        OVR_PINS = 2'b00,
        OVR_AUTO = 2'b01,
        OVR_THRU = 2'b10,
        OVR_OFF  = 2'b11
    } ovr_e;

    typedef struct packed {
        op_mode_e mode;
        logic     uv;
        logic     ov;
        logic     ot;
        logic     hot;
        logic     g_ls;
        logic     g_hs;
        logic     g_byp;
        logic     g_dis;
    } arb_state_t;

endpackage

// File: rtl/hyst_next.sv
// Next value of one hysteretic flag. ABOVE=1: trips above SET and releases
// below CLR. ABOVE=0: trips below SET and releases above CLR.
module hyst_next #(
    parameter int W     = 10,
    parameter int SET   = 160,
    parameter int CLR   = 170,
    parameter bit ABOVE = 1'b0
) (
    input  logic [W-1:0] code,
    input  logic         cur,
    output logic         nxt
);
    logic trip, rel;

    generate
        if (ABOVE) begin : g_high
            assign trip = code > W'(SET);
            assign rel  = code < W'(CLR);
        end else begin : g_low
            assign trip = code < W'(SET);
            assign rel  = code > W'(CLR);
        end
    endgenerate

    assign nxt = cur ? !rel : trip;
endmodule

// File: rtl/qual_next.sv
// Saturating count of consecutive enable-high edges.
module qual_next #(
    parameter int LIMIT = 3001,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          en,
    input  logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nxt,
    output logic          qualified
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    always_comb begin
        if (!en)             cnt_nxt = '0;
        else if (cnt >= LIM) cnt_nxt = LIM;
        else                 cnt_nxt = cnt + 1'b1;
    end

    assign qualified = cnt_nxt >= LIM;
endmodule

// File: rtl/mode_pick.sv
module mode_pick
    import pmarb_pkg::*;
(
    input  logic     en,
    input  logic     nbyp,
    input  logic [1:0] ovr,
    input  logic     qualified,
    output op_mode_e mode
);
    op_mode_e auto_or_thru;

    assign auto_or_thru = qualified ? MODE_AUTO : MODE_THRU;

    always_comb begin
        if (!en) begin
            mode = MODE_OFF;
        end else begin
            unique case (ovr_e'(ovr))
                OVR_OFF:  mode = MODE_OFF;
                OVR_THRU: mode = MODE_THRU;
                OVR_AUTO: mode = auto_or_thru;
                default:  mode = nbyp ? auto_or_thru : MODE_THRU;
            endcase
        end
    end
endmodule

// File: rtl/power_mode_arbiter.sv
module power_mode_arbiter
    import pmarb_pkg::*;
#(
    parameter int VW          = 10,
    parameter int TW          = 8,
    parameter int UV_SET      = 160,
    parameter int UV_CLR      = 170,
    parameter int OV_SET      = 600,
    parameter int OV_CLR      = 570,
    parameter int OT_SET      = 160,
    parameter int OT_CLR      = 140,
    parameter int HD_SET      = 100,
    parameter int HD_CLR      = 90,
    parameter int QUAL_CYCLES = 3001
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_pin,
    input  logic          nbyp_pin,
    input  logic [1:0]    ovr_sel,
    input  logic [VW-1:0] vin_code,
    input  logic [TW-1:0] temp_code,
    output logic [1:0]    mode,
    output logic          ls_en,
    output logic          hs_en,
    output logic          byp_en,
    output logic          dis_en,
    output logic          uv_flag,
    output logic          ov_flag,
    output logic          ot_flag,
    output logic          hot_flag
);
    localparam int CW = $clog2(QUAL_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        arb_state_t    st;
    } regs_t;

    localparam arb_state_t ST_RST = '{mode: MODE_OFF, uv: 1'b1, ov: 1'b0,
                                      ot: 1'b0, hot: 1'b0, g_ls: 1'b0,
                                      g_hs: 1'b0, g_byp: 1'b0, g_dis: 1'b1};

    regs_t r_d, r_q;

    logic          uv_n, ov_n, ot_n, hot_n, qual_ok;
    logic [CW-1:0] cnt_n;
    op_mode_e      mode_n;

    hyst_next #(.W(VW), .SET(UV_SET), .CLR(UV_CLR), .ABOVE(1'b0)) u_uv (
        .code(vin_code), .cur(r_q.st.uv), .nxt(uv_n));
    hyst_next #(.W(VW), .SET(OV_SET), .CLR(OV_CLR), .ABOVE(1'b1)) u_ov (
        .code(vin_code), .cur(r_q.st.ov), .nxt(ov_n));
    hyst_next #(.W(TW), .SET(OT_SET), .CLR(OT_CLR), .ABOVE(1'b1)) u_ot (
        .code(temp_code), .cur(r_q.st.ot), .nxt(ot_n));
    hyst_next #(.W(TW), .SET(HD_SET), .CLR(HD_CLR), .ABOVE(1'b1)) u_hot (
        .code(temp_code), .cur(r_q.st.hot), .nxt(hot_n));

    qual_next #(.LIMIT(QUAL_CYCLES), .CW(CW)) u_qual (
        .en(en_pin), .cnt(r_q.cnt), .cnt_nxt(cnt_n), .qualified(qual_ok));

    mode_pick u_pick (
        .en(en_pin), .nbyp(nbyp_pin), .ovr(ovr_sel),
        .qualified(qual_ok), .mode(mode_n));

    always_comb begin
        logic fault;
        r_d          = r_q;
        r_d.cnt      = cnt_n;
        r_d.st.uv    = uv_n;
        r_d.st.ov    = ov_n;
        r_d.st.ot    = ot_n;
        r_d.st.hot   = hot_n;
        r_d.st.mode  = mode_n;
        fault        = uv_n | ov_n | ot_n;
        r_d.st.g_ls  = (mode_n == MODE_AUTO) && !fault;
        r_d.st.g_hs  = (mode_n == MODE_AUTO) && !fault;
        r_d.st.g_byp = (mode_n != MODE_OFF) && !fault;
        r_d.st.g_dis = (mode_n == MODE_OFF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cnt <= '0;
            r_q.st  <= ST_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign mode     = r_q.st.mode;
    assign ls_en    = r_q.st.g_ls;
    assign hs_en    = r_q.st.g_hs;
    assign byp_en   = r_q.st.g_byp;
    assign dis_en   = r_q.st.g_dis;
    assign uv_flag  = r_q.st.uv;
    assign ov_flag  = r_q.st.ov;
    assign ot_flag  = r_q.st.ot;
    assign hot_flag = r_q.st.hot;
endmodule

// File: rtl/power_mode_arbiter_chk.sv
module power_mode_arbiter_chk #(
    parameter int VW          = 10,
    parameter int TW          = 8,
    parameter int UV_SET      = 160,
    parameter int OT_SET      = 160,
    parameter int QUAL_CYCLES = 3001
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_pin,
    input logic [1:0]    ovr_sel,
    input logic [VW-1:0] vin_code,
    input logic [TW-1:0] temp_code,
    input logic [1:0]    mode,
    input logic          ls_en,
    input logic          hs_en,
    input logic          byp_en,
    input logic          dis_en,
    input logic          uv_flag,
    input logic          ov_flag,
    input logic          ot_flag
);
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  run_q <= 0;
        else if (!en_pin)            run_q <= 0;
        else if (run_q < QUAL_CYCLES) run_q <= run_q + 1;
    end

    AST_EN_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_pin |=> mode == 2'b00); // R1
    AST_AUTO_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b10 |-> run_q >= QUAL_CYCLES); // R3
    AST_OVR_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_pin && ovr_sel == 2'b11) |=> mode == 2'b00); // R4
    AST_UV_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        vin_code < VW'(UV_SET) |=> uv_flag); // R5
    AST_OT_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        temp_code > TW'(OT_SET) |=> ot_flag); // R7
    AST_OFF_DISCHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b00 |-> dis_en && !ls_en && !hs_en && !byp_en); // R9
    AST_FAULT_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_flag || ov_flag || ot_flag) |-> !ls_en && !hs_en && !byp_en); // R10
endmodule

bind power_mode_arbiter power_mode_arbiter_chk #(
    .VW(VW), .TW(TW), .UV_SET(UV_SET), .OT_SET(OT_SET),
    .QUAL_CYCLES(QUAL_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .ovr_sel(ovr_sel),
    .vin_code(vin_code), .temp_code(temp_code), .mode(mode),
    .ls_en(ls_en), .hs_en(hs_en), .byp_en(byp_en), .dis_en(dis_en),
    .uv_flag(uv_flag), .ov_flag(ov_flag), .ot_flag(ot_flag)
);

// File: tb/power_mode_arbiter_test.sv
module power_mode_arbiter_test;
    import pmarb_pkg::*;

    localparam int QUAL = 3001;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_pin = 1'b0, nbyp_pin = 1'b0;
    logic [1:0] ovr_sel = 2'b00;
    logic [9:0] vin_code = 10'd0;
    logic [7:0] temp_code = 8'd25;
    logic [1:0] mode;
    logic       ls_en, hs_en, byp_en, dis_en, uv_flag, ov_flag, ot_flag, hot_flag;

    int checks = 0;
    int errors = 0;

    arb_state_t exp_q[$];
    string      tag_q[$];

    // model state
    bit m_uv = 1'b1, m_ov = 1'b0, m_ot = 1'b0, m_hot = 1'b0;
    int m_cnt = 0;

    always #10 clk = ~clk;

    power_mode_arbiter uut (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .nbyp_pin(nbyp_pin),
        .ovr_sel(ovr_sel), .vin_code(vin_code), .temp_code(temp_code),
        .mode(mode), .ls_en(ls_en), .hs_en(hs_en), .byp_en(byp_en),
        .dis_en(dis_en), .uv_flag(uv_flag), .ov_flag(ov_flag),
        .ot_flag(ot_flag), .hot_flag(hot_flag));

    function automatic arb_state_t actual();
        arb_state_t a;
        a.mode = op_mode_e'(mode);
        a.uv = uv_flag; a.ov = ov_flag; a.ot = ot_flag; a.hot = hot_flag;
        a.g_ls = ls_en; a.g_hs = hs_en; a.g_byp = byp_en; a.g_dis = dis_en;
        return a;
    endfunction

    task automatic compare(input arb_state_t e, input string tag);
        arb_state_t a = actual();
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, a, e);
        end
    endtask

    // monitor: results are due one edge after stimulus (R11)
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end

    // driver: apply inputs on falling edge, model requirements, queue expectation
    task automatic step(input bit en, input bit nb, input logic [1:0] ov,
                        input int v, input int t, input bit chk, input string tag);
        op_mode_e md;
        bit q, flt;
        arb_state_t e;
        @(negedge clk);
        en_pin = en; nbyp_pin = nb; ovr_sel = ov;
        vin_code = 10'(v); temp_code = 8'(t);
        m_uv  = m_uv  ? !(v > 170) : (v < 160);
        m_ov  = m_ov  ? !(v < 570) : (v > 600);
        m_ot  = m_ot  ? !(t < 140) : (t > 160);
        m_hot = m_hot ? !(t < 90)  : (t > 100);
        m_cnt = en ? ((m_cnt >= QUAL) ? QUAL : m_cnt + 1) : 0;
        q = (m_cnt >= QUAL);
        if (!en)            md = MODE_OFF;
        else if (ov == 2'b11) md = MODE_OFF;
        else if (ov == 2'b10) md = MODE_THRU;
        else if (ov == 2'b01 || nb) md = q ? MODE_AUTO : MODE_THRU;
        else                md = MODE_THRU;
        flt = m_uv | m_ov | m_ot;
        e.mode = md; e.uv = m_uv; e.ov = m_ov; e.ot = m_ot; e.hot = m_hot;
        e.g_ls = (md == MODE_AUTO) && !flt;
        e.g_hs = (md == MODE_AUTO) && !flt;
        e.g_byp = (md != MODE_OFF) && !flt;
        e.g_dis = (md == MODE_OFF);
        if (chk) begin
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
    endtask

    initial begin : watchdog
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        arb_state_t rst_exp;
        rst_exp = '{mode: MODE_OFF, uv: 1'b1, ov: 1'b0, ot: 1'b0, hot: 1'b0,
                    g_ls: 1'b0, g_hs: 1'b0, g_byp: 1'b0, g_dis: 1'b1};
        repeat (3) @(negedge clk);
        compare(rst_exp, "R11 reset state / R5 uv reset");
        rst_n = 1'b1;

        // off with either pin level (R1), undervoltage release (R5)
        step(0, 0, 2'b00, 300, 25, 1, "R1 off nbyp low / R5 release");
        step(0, 1, 2'b00, 300, 25, 1, "R1 off nbyp high");
        step(0, 1, 2'b11, 300, 25, 1, "R1 off ignores override");
        // pass-through from pins (R2, R9)
        step(1, 0, 2'b00, 300, 25, 1, "R2 pass-through / R9 bypass only");
        step(0, 0, 2'b00, 300, 25, 1, "R1 back to off");
        // qualification window (R3)
        step(1, 1, 2'b00, 300, 25, 1, "R3 edge 1 still pass-through");
        for (int i = 0; i < QUAL - 3; i++) step(1, 1, 2'b00, 300, 25, 0, "");
        step(1, 1, 2'b00, 300, 25, 1, "R3 edge before limit pass-through");
        step(1, 1, 2'b00, 300, 25, 1, "R3 auto at limit / R9 all gates");
        step(1, 0, 2'b00, 300, 25, 1, "R2 nbyp low drops to pass-through");
        // overrides (R4)
        step(1, 1, 2'b10, 300, 25, 1, "R4 override pass-through");
        step(1, 1, 2'b11, 300, 25, 1, "R4 override off");
        step(1, 0, 2'b01, 300, 25, 1, "R4 override auto with nbyp low");
        step(0, 0, 2'b01, 300, 25, 1, "R4 override needs enable");
        step(1, 0, 2'b01, 300, 25, 1, "R4 override auto unqualified");
        for (int i = 0; i < QUAL; i++) step(1, 0, 2'b01, 300, 25, 0, "");
        step(1, 0, 2'b01, 300, 25, 1, "R4 override auto qualified");
        // undervoltage hysteresis (R5, R10)
        step(1, 0, 2'b01, 165, 25, 1, "R5 hold clear between thresholds");
        step(1, 0, 2'b01, 159, 25, 1, "R5 trip / R10 gates off");
        step(1, 0, 2'b01, 165, 25, 1, "R5 hold set between thresholds");
        step(1, 0, 2'b01, 171, 25, 1, "R5 release");
        // overvoltage (R6)
        step(1, 0, 2'b01, 601, 25, 1, "R6 trip / R10");
        step(1, 0, 2'b01, 580, 25, 1, "R6 hold");
        step(1, 0, 2'b01, 569, 25, 1, "R6 release");
        // over-temperature (R7) with warm-die flag (R8)
        step(1, 0, 2'b01, 300, 161, 1, "R7 trip / R10 / R8 set");
        step(1, 0, 2'b01, 300, 150, 1, "R7 hold");
        step(1, 0, 2'b01, 300, 139, 1, "R7 release, R8 still set");
        step(1, 0, 2'b01, 300, 95, 1, "R8 hold, gates unaffected");
        step(1, 0, 2'b01, 300, 89, 1, "R8 release");
        step(1, 0, 2'b01, 300, 101, 1, "R8 set without gating");
        step(1, 0, 2'b00, 300, 25, 1, "R2 pins again pass-through");
        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule